// File: doc/BRIEF.md
# Strobed Reed-Switch Sampler with Hysteresis Debounce

This block reads a reed-switch line that has no permanent pull-up. On every sample-rate tick it turns on the pull-up for a fixed charging interval. It samples the line in the last cycle of that interval and then turns the pull-up off again, so the line can drain toward ground between strobes. This keeps the average current through the pull-up small.

Each sensed bit drives a saturating up/down integrator that runs from zero to a ceiling (4 by default). The debounced level only changes when the integrator reaches one end of its range. Because of this, a short run of bounce or noise moves the integrator but does not change the level. Each change of the debounced level produces a one-cycle edge pulse, which a separate counter block can consume.

An optional input synchronizer can be placed in front of the sampling point. It is selected by a parameter and is bypassed by default.

Top module: `reed_strobe_debounce`

## Requirements
- R1: One cycle after a clock edge that sees `rate_tick` high while the block is idle, `pullup_en` goes high. It stays high for exactly CHARGE_CYCLES cycles (default 2) and is low at all other times.
- R2: A `rate_tick` seen on any edge while `pullup_en` is high, including the last strobe cycle, is ignored. It neither extends nor restarts the strobe.
- R3: `line_in` is sampled only at the clock edge that ends the last strobe cycle. With SYNC_STAGES = 0 (the default), its value at any other time has no effect.
- R4: While `rst_n` is low, the integrator is loaded with INTEG_MAX (default 4). During reset `level_out` is 1, and `pullup_en`, `fall_pulse` and `rise_pulse` are 0.
- R5: A sensed 1 adds one to the integrator and a sensed 0 subtracts one. The value saturates at 0 and at INTEG_MAX.
- R6: While `level_out` is 1, it goes to 0 only when the integrator reaches 0.
- R7: While `level_out` is 0, it goes to 1 only when the integrator reaches INTEG_MAX.
- R8: `level_out` can change only at the sampling edge. A change is therefore visible in the cycle right after a cycle in which `pullup_en` was high.
- R9: `fall_pulse` is high for exactly the one cycle in which `level_out` first reads 0 after being 1. It is low otherwise.
- R10: `rise_pulse` is high for exactly the one cycle in which `level_out` first reads 1 after being 0. It is low otherwise.
- R11: When the level is high and the integrator is full, a run of fewer than INTEG_MAX consecutive zeros followed by a one leaves `level_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_tick | input | 1 | Sample-rate tick; starts a strobe when the block is idle |
| line_in | input | 1 | Raw sensed switch line |
| pullup_en | output | 1 | Pull-up enable strobe, high = pull-up on |
| level_out | output | 1 | Debounced switch level |
| fall_pulse | output | 1 | One-cycle pulse when the debounced level goes low |
| rise_pulse | output | 1 | One-cycle pulse when the debounced level goes high |

## Verification
The hardest situations to reach are the integrator at a saturation limit with the level already switched, and a one-step reversal just after a level switch. In both cases the next sample must move the count without making an edge pulse. The stimulus table walks the integrator down past zero and back up past the ceiling with single-step reversals placed at both ends.

Sampling at one edge is exercised by driving the opposite value on `line_in` for the early part of selected strobes. A tick held high across a whole strobe shows that ticks arriving during a strobe are dropped.

// File: rtl/reed_deb_pkg.sv
package reed_deb_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/reed_line_sync.sv
module reed_line_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_sync
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign line_sync = line_raw;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= line_raw;
            else chain <= {chain[STAGES-2:0], line_raw};
         end
         assign line_sync = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/reed_strobe_gen.sv
module reed_strobe_gen #(
   parameter int unsigned CHARGE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_tick,
   output logic strobe_on,
   output logic sample_now
);
   localparam int unsigned RW = (CHARGE_CYCLES > 1) ? $clog2(CHARGE_CYCLES) : 1;
   localparam logic [RW-1:0] LAST = RW'(CHARGE_CYCLES - 1);

   logic          active;
   logic [RW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         remain <= '0;
      end else if (!active) begin
         if (rate_tick) begin
            active <= 1'b1;
            remain <= LAST;
         end
      end else if (remain == '0) begin
         active <= 1'b0;
      end else begin
         remain <= remain - 1'b1;
      end
   end

   assign strobe_on  = active;
   assign sample_now = active && (remain == '0);
endmodule

// File: rtl/reed_integrator.sv
module reed_integrator
   import reed_deb_pkg::*;
#(
   parameter int unsigned INTEG_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_vld,
   input  logic sample_bit,
   output logic level,
   output logic fall_evt,
   output logic rise_evt
);
   localparam int unsigned CW = cnt_width(INTEG_MAX);
   localparam logic [CW-1:0] TOP = CW'(INTEG_MAX);

   logic [CW-1:0] count, count_nxt;
   logic          level_nxt;
   step_e         step;

   always_comb begin
      step = STEP_HOLD;
      if (sample_vld) begin
         if (sample_bit) begin
            if (count != TOP) step = STEP_UP;
         end else begin
            if (count != '0) step = STEP_DOWN;
         end
      end
      unique case (step)
         STEP_UP:   count_nxt = count + 1'b1;
         STEP_DOWN: count_nxt = count - 1'b1;
         default:   count_nxt = count;
      endcase
      level_nxt = level;
      if (level && (count_nxt == '0)) level_nxt = 1'b0;
      else if (!level && (count_nxt == TOP)) level_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= TOP;
         level    <= 1'b1;
         fall_evt <= 1'b0;
         rise_evt <= 1'b0;
      end else begin
         count    <= count_nxt;
         level    <= level_nxt;
         fall_evt <= level & ~level_nxt;
         rise_evt <= ~level & level_nxt;
      end
   end
endmodule

// File: rtl/reed_strobe_debounce.sv
module reed_strobe_debounce #(
   parameter int unsigned CHARGE_CYCLES = 2,
   parameter int unsigned INTEG_MAX     = 4,
   parameter int unsigned SYNC_STAGES   = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_tick,
   input  logic line_in,
   output logic pullup_en,
   output logic level_out,
   output logic fall_pulse,
   output logic rise_pulse
);
   initial begin
      if (CHARGE_CYCLES < 1) $error("CHARGE_CYCLES must be at least 1");
      if (INTEG_MAX < 1)     $error("INTEG_MAX must be at least 1");
      if (SYNC_STAGES > 4)   $error("SYNC_STAGES must be 4 or less");
   end

   logic line_s;
   logic sample_now;

   reed_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_raw  (line_in),
      .line_sync (line_s)
   );

   reed_strobe_gen #(.CHARGE_CYCLES(CHARGE_CYCLES)) u_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_tick  (rate_tick),
      .strobe_on  (pullup_en),
      .sample_now (sample_now)
   );

   reed_integrator #(.INTEG_MAX(INTEG_MAX)) u_integ (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_vld (sample_now),
      .sample_bit (line_s),
      .level      (level_out),
      .fall_evt   (fall_pulse),
      .rise_evt   (rise_pulse)
   );
endmodule

// File: rtl/reed_strobe_debounce_chk.sv
module reed_strobe_debounce_chk #(
   parameter int unsigned CHARGE_CYCLES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic pullup_en,
   input logic level_out,
   input logic fall_pulse,
   input logic rise_pulse
);
   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= 0;
      else if (pullup_en) run_len <= run_len + 1;
      else run_len <= 0;
   end

   // R1, R2: a strobe never outlasts the charge interval
   assert_strobe_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_en |-> (run_len < CHARGE_CYCLES));

   // R1, R2: every finished strobe lasted exactly the charge interval
   assert_strobe_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pullup_en && run_len != 0) |-> (run_len == CHARGE_CYCLES));

   assert_level_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out != $past(level_out)) |-> ($past(pullup_en) && !pullup_en));

   assert_fall_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pulse == $fell(level_out));

   assert_rise_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse == $rose(level_out));

   assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_pulse && rise_pulse));
endmodule

bind reed_strobe_debounce reed_strobe_debounce_chk #(.CHARGE_CYCLES(CHARGE_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pullup_en  (pullup_en),
   .level_out  (level_out),
   .fall_pulse (fall_pulse),
   .rise_pulse (rise_pulse)
);

// File: tb/reed_strobe_debounce_bench.sv
module reed_strobe_debounce_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_tick = 1'b0;
   logic line_in = 1'b0;
   logic pullup_en, level_out, fall_pulse, rise_pulse;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   reed_strobe_debounce u_reed_strobe_debounce (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_tick  (rate_tick),
      .line_in    (line_in),
      .pullup_en  (pullup_en),
      .level_out  (level_out),
      .fall_pulse (fall_pulse),
      .rise_pulse (rise_pulse)
   );

   // {sensed, decoy, level, fall, rise}; starting count 4, level 1
   localparam int NV = 16;
   localparam logic [4:0] VEC [NV] = '{
      5'b0_0_100, // 4->3
      5'b1_1_100, // 3->4 bounce
      5'b0_0_100, // 4->3
      5'b0_1_100, // 3->2
      5'b0_0_100, // 2->1
      5'b0_0_010, // 1->0 level low
      5'b0_1_000, // saturate at 0
      5'b1_0_000, // 0->1
      5'b0_0_000, // 1->0, already low
      5'b1_1_000, // 0->1
      5'b1_0_000, // 1->2
      5'b1_0_000, // 2->3
      5'b1_0_101, // 3->4 level high
      5'b1_1_100, // saturate at 4
      5'b0_0_100, // 4->3
      5'b1_0_100  // 3->4
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one strobe: tick, decoy value early, real value in last strobe cycle
   task automatic do_sample(input bit v, input bit decoy);
      @(negedge clk);
      rate_tick = 1'b1;
      line_in = decoy ? ~v : v;
      @(negedge clk);
      rate_tick = 1'b0;
      check(pullup_en === 1'b1, "R1", "strobe cycle 1", int'(pullup_en), 1);
      @(negedge clk);
      check(pullup_en === 1'b1, "R1", "strobe cycle 2", int'(pullup_en), 1);
      line_in = v;
      @(negedge clk);
      check(pullup_en === 1'b0, "R1", "strobe end", int'(pullup_en), 0);
      line_in = ~v;
   endtask

   initial begin
      #200000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(level_out === 1'b1, "R4", "reset level", int'(level_out), 1);
      check(pullup_en === 1'b0, "R4", "reset pullup", int'(pullup_en), 0);
      check(fall_pulse === 1'b0 && rise_pulse === 1'b0, "R4", "reset pulses",
            int'({fall_pulse, rise_pulse}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pullup_en === 1'b0, "R1", "idle without tick", int'(pullup_en), 0);

      // R3 R5 R6 R7 R11 table walk
      for (int i = 0; i < NV; i++) begin
         do_sample(VEC[i][4], VEC[i][3]);
         check(level_out === VEC[i][2], "R5/R6/R7/R11", $sformatf("vec %0d level", i),
               int'(level_out), int'(VEC[i][2]));
         check(fall_pulse === VEC[i][1], "R9", $sformatf("vec %0d fall", i),
               int'(fall_pulse), int'(VEC[i][1]));
         check(rise_pulse === VEC[i][0], "R10", $sformatf("vec %0d rise", i),
               int'(rise_pulse), int'(VEC[i][0]));
         @(negedge clk);
         check(fall_pulse === 1'b0 && rise_pulse === 1'b0, "R9/R10",
               $sformatf("vec %0d pulse width", i), int'({fall_pulse, rise_pulse}), 0);
         check(level_out === VEC[i][2], "R8", $sformatf("vec %0d level hold", i),
               int'(level_out), int'(VEC[i][2]));
      end

      // R2: tick held across whole strobe, count 4, sense zeros
      line_in = 1'b0;
      @(negedge clk);
      rate_tick = 1'b1;
      @(negedge clk);
      check(pullup_en === 1'b1, "R2", "held tick c1", int'(pullup_en), 1);
      @(negedge clk);
      check(pullup_en === 1'b1, "R2", "held tick c2", int'(pullup_en), 1);
      @(negedge clk);
      rate_tick = 1'b0;
      check(pullup_en === 1'b0, "R2", "held tick end", int'(pullup_en), 0);
      @(negedge clk);
      check(pullup_en === 1'b0, "R2", "no restart", int'(pullup_en), 0);
      // one sample taken (4->3): three more zeros reach 0
      do_sample(1'b0, 1'b0);
      do_sample(1'b0, 1'b0);
      check(level_out === 1'b1, "R2/R6", "level before last", int'(level_out), 1);
      do_sample(1'b0, 1'b0);
      check(level_out === 1'b0 && fall_pulse === 1'b1, "R2/R6", "fall after 4 zeros",
            int'({level_out, fall_pulse}), 1);

      // R3: line toggling without a strobe has no effect
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         line_in = k[0];
      end
      @(negedge clk);
      check(level_out === 1'b0 && rise_pulse === 1'b0, "R3", "no strobe no change",
            int'(level_out), 0);

      // R4: reset mid operation
      rst_n = 1'b0;
      @(negedge clk);
      check(level_out === 1'b1 && pullup_en === 1'b0, "R4", "reset again",
            int'({level_out, pullup_en}), 2);
      rst_n = 1'b1;
      @(negedge clk);
      do_sample(1'b0, 1'b1);
      check(level_out === 1'b1, "R4/R5", "count restored to top", int'(level_out), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule